// File: doc/BRIEF.md
# Ordered Mailbox FIFO Channel

This block is one channel of a unidirectional mailbox. A sender pushes payload words into it and a receiver pops them, always in the order they went in. The sender does not have to wait for earlier words to be consumed: it may keep pushing while there is room. Each word carries a flag that says whether the receiver must acknowledge it. When the receiver pops a flagged word and then writes its acknowledge strobe, a sticky interrupt rises on the sender side.

Every interrupt is a level. Two of them follow the fill level against programmable marks: the low-tide interrupt holds while the fill is at or below its mark, and the high-tide interrupt holds while the fill is at or above its mark. The receiver's transfer interrupt holds while any word is waiting. A flush request discards every stored word, resets the pointers and latches a flush interrupt. A push into a full channel is dropped and latches an overflow status bit. The channel depth is a parameter and is also driven on an output, so software can read it at run time. A system with several channels simply places several instances, numbered from 0.

Top module: `mbox_fifo_chan`

## Requirements
- R1: After a synchronous reset, fill_level is 0, rcv_rd_data and rcv_rd_needack are 0, and irq_rcv_xfer, irq_high_tide (when cfg_high_mark > 0), irq_snd_ack, irq_flush and ovf_sticky are 0.
- R2: A pop with rcv_rd_en in cycle N shows the oldest stored word and its acknowledge-required flag on rcv_rd_data and rcv_rd_needack from cycle N+1 and holds them until the next pop. Words leave in exactly the order they were accepted.
- R3: A push while fill_level equals DEPTH is dropped, even if a pop happens in the same cycle. The drop sets ovf_sticky, which stays 1 until a cycle with snd_ovf_clr and no new drop.
- R4: A pop while the channel is empty loads 0 into rcv_rd_data and rcv_rd_needack and changes no stored state. A push in that same cycle is still accepted.
- R5: irq_rcv_xfer is 1 exactly when fill_level is nonzero.
- R6: irq_high_tide is 1 exactly when fill_level >= cfg_high_mark.
- R7: irq_low_tide is 1 exactly when fill_level <= cfg_low_mark.
- R8: A popped word with its flag set makes an acknowledge pending. A later rcv_ack while pending sets irq_snd_ack and clears the pending state. rcv_ack with nothing pending has no effect. irq_snd_ack stays 1 until snd_ack_clr, and a new set in the same cycle as the clear wins.
- R9: snd_flush empties the channel on the next edge (fill_level 0). It ignores any push, pop or acknowledge in the same cycle, leaves rcv_rd_data unchanged, drops a pending acknowledge and sets irq_flush. irq_flush stays 1 until snd_flush_clr, and the set wins over a clear in the same cycle.
- R10: depth_value always equals DEPTH.
- R11: A push and a pop in the same cycle, with the channel neither full nor empty, leave fill_level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| snd_wr_en | input | 1 | Sender pushes a word |
| snd_wr_data | input | DW | Payload of the pushed word |
| snd_wr_needack | input | 1 | Pushed word requires an acknowledgment |
| snd_flush | input | 1 | Discard all stored words |
| snd_ack_clr | input | 1 | Write-1 clear of irq_snd_ack |
| snd_flush_clr | input | 1 | Write-1 clear of irq_flush |
| snd_ovf_clr | input | 1 | Write-1 clear of ovf_sticky |
| cfg_low_mark | input | CW | Low-tide threshold |
| cfg_high_mark | input | CW | High-tide threshold |
| rcv_rd_en | input | 1 | Receiver pops a word |
| rcv_ack | input | 1 | Receiver acknowledges the last flagged word |
| rcv_rd_data | output | DW | Last popped payload |
| rcv_rd_needack | output | 1 | Flag of the last popped word |
| fill_level | output | CW | Number of stored words |
| depth_value | output | CW | Constant channel depth |
| ovf_sticky | output | 1 | A push was dropped |
| irq_rcv_xfer | output | 1 | Receiver: data available |
| irq_snd_ack | output | 1 | Sender: acknowledgment received |
| irq_low_tide | output | 1 | Fill at or below low mark |
| irq_high_tide | output | 1 | Fill at or above high mark |
| irq_flush | output | 1 | Flush occurred |

## Verification
The assertions check on every cycle that the fill never passes DEPTH, that a push into a full channel leaves it full and sets the overflow bit, and that an empty pop yields zero. They also check that a balanced push and pop keeps the fill, that the sticky interrupts hold until cleared, that a flush empties the channel, and that the two tide levels never both hold when the low mark is below the high mark. Payload ordering, the acknowledge round trip from a flagged word to the sender interrupt, and the precedence of flush over same-cycle traffic involve stored data and sequences. Only the bench's scenarios, compared against its reference queue, can show these.

// File: rtl/mbox_fifo_pkg.sv
package mbox_fifo_pkg;

  // encoding of the per-cycle storage operation: {pop, push}
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_BOTH = 2'b11
  } fifo_op_e;

  function automatic int unsigned ptr_bits(input int unsigned depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction

endpackage

// File: rtl/mbox_fifo_store.sv
module mbox_fifo_store
  import mbox_fifo_pkg::*;
#(
  parameter  int DW    = 32,
  parameter  int DEPTH = 16,
  localparam int AW    = ptr_bits(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int EW    = DW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  input  logic          push_ack,
  input  logic          pop_req,
  output logic [DW-1:0] pop_data,
  output logic          pop_ack,
  output logic          pop_vld,
  output logic [CW-1:0] fill,
  output logic          drop
);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          is_full, is_empty, do_push, do_pop;
  fifo_op_e      op;

  assign is_full  = (fill == CW'(DEPTH));
  assign is_empty = (fill == '0);
  assign do_push  = push_req & ~is_full & ~flush;
  assign do_pop   = pop_req & ~is_empty & ~flush;
  assign drop     = push_req & is_full & ~flush;
  assign op       = fifo_op_e'({do_pop, do_push});

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // storage array: write port only, no reset, suits block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= {push_ack, push_data};
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      case (op)
        OP_PUSH: begin
          wptr <= bump(wptr);
          fill <= fill + CW'(1);
        end
        OP_POP: begin
          rptr <= bump(rptr);
          fill <= fill - CW'(1);
        end
        OP_BOTH: begin
          wptr <= bump(wptr);
          rptr <= bump(rptr);
        end
        default: ;
      endcase
    end
  end

  // registered read port; an empty pop yields zero
  always_ff @(posedge clk) begin
    if (rst) begin
      pop_data <= '0;
      pop_ack  <= 1'b0;
      pop_vld  <= 1'b0;
    end else begin
      pop_vld <= do_pop;
      if (pop_req && !flush) begin
        if (is_empty) {pop_ack, pop_data} <= '0;
        else          {pop_ack, pop_data} <= mem[rptr];
      end
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (is_full && push_req && !pop_req && !flush) |=> (fill == CW'(DEPTH))); // R3
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    (is_empty && pop_req && !push_req && !flush) |=> (pop_data == '0 && fill == '0)); // R4
  AST_BALANCED: assert property (@(posedge clk) disable iff (rst)
    (push_req && pop_req && !is_full && !is_empty && !flush) |=> $stable(fill)); // R11
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> (fill == '0)); // R9

endmodule

// File: rtl/mbox_fifo_events.sv
module mbox_fifo_events (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic flush_clr,
  input  logic drop,
  input  logic ovf_clr,
  input  logic pop_vld,
  input  logic pop_ack,
  input  logic rcv_ack,
  input  logic ack_clr,
  output logic irq_ack,
  output logic irq_flush,
  output logic ovf
);

  logic pend_q, eff_pend, ack_hit;

  // a flagged pop becomes pending in the same cycle its data is visible
  assign eff_pend = pend_q | (pop_vld & pop_ack);
  assign ack_hit  = rcv_ack & eff_pend & ~flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      irq_ack   <= 1'b0;
      irq_flush <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      pend_q    <= (flush | ack_hit) ? 1'b0 : eff_pend;
      irq_ack   <= ack_hit | (irq_ack & ~ack_clr);
      irq_flush <= flush | (irq_flush & ~flush_clr);
      ovf       <= drop | (ovf & ~ovf_clr);
    end
  end

  AST_ACK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !ack_clr) |=> irq_ack); // R8
  AST_ACK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!rcv_ack && !irq_ack) |=> !irq_ack); // R8
  AST_FLUSH_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flush || (irq_flush && !flush_clr)) |=> irq_flush); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (drop || (ovf && !ovf_clr)) |=> ovf); // R3

endmodule

// File: rtl/mbox_fifo_tide.sv
module mbox_fifo_tide #(
  parameter int CW = 5
) (
  input  logic [CW-1:0] fill,
  input  logic [CW-1:0] low_mark,
  input  logic [CW-1:0] high_mark,
  output logic          irq_low,
  output logic          irq_high,
  output logic          irq_avail
);

  always_comb begin
    irq_low   = (fill <= low_mark);
    irq_high  = (fill >= high_mark);
    irq_avail = (fill != '0);
  end

endmodule

// File: rtl/mbox_fifo_chan.sv
module mbox_fifo_chan #(
  parameter  int DW    = 32,
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          snd_wr_en,
  input  logic [DW-1:0] snd_wr_data,
  input  logic          snd_wr_needack,
  input  logic          snd_flush,
  input  logic          snd_ack_clr,
  input  logic          snd_flush_clr,
  input  logic          snd_ovf_clr,
  input  logic [CW-1:0] cfg_low_mark,
  input  logic [CW-1:0] cfg_high_mark,
  input  logic          rcv_rd_en,
  input  logic          rcv_ack,
  output logic [DW-1:0] rcv_rd_data,
  output logic          rcv_rd_needack,
  output logic [CW-1:0] fill_level,
  output logic [CW-1:0] depth_value,
  output logic          ovf_sticky,
  output logic          irq_rcv_xfer,
  output logic          irq_snd_ack,
  output logic          irq_low_tide,
  output logic          irq_high_tide,
  output logic          irq_flush
);

  logic pop_vld, drop;

  assign depth_value = CW'(DEPTH);

  mbox_fifo_store #(.DW(DW), .DEPTH(DEPTH)) store_i (
    .clk       (clk),
    .rst       (rst),
    .flush     (snd_flush),
    .push_req  (snd_wr_en),
    .push_data (snd_wr_data),
    .push_ack  (snd_wr_needack),
    .pop_req   (rcv_rd_en),
    .pop_data  (rcv_rd_data),
    .pop_ack   (rcv_rd_needack),
    .pop_vld   (pop_vld),
    .fill      (fill_level),
    .drop      (drop)
  );

  mbox_fifo_events events_i (
    .clk       (clk),
    .rst       (rst),
    .flush     (snd_flush),
    .flush_clr (snd_flush_clr),
    .drop      (drop),
    .ovf_clr   (snd_ovf_clr),
    .pop_vld   (pop_vld),
    .pop_ack   (rcv_rd_needack),
    .rcv_ack   (rcv_ack),
    .ack_clr   (snd_ack_clr),
    .irq_ack   (irq_snd_ack),
    .irq_flush (irq_flush),
    .ovf       (ovf_sticky)
  );

  mbox_fifo_tide #(.CW(CW)) tide_i (
    .fill      (fill_level),
    .low_mark  (cfg_low_mark),
    .high_mark (cfg_high_mark),
    .irq_low   (irq_low_tide),
    .irq_high  (irq_high_tide),
    .irq_avail (irq_rcv_xfer)
  );

  AST_TIDE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    (cfg_low_mark < cfg_high_mark) |-> !(irq_low_tide && irq_high_tide)); // R6 R7
  AST_XFER_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    $rose(fill_level != '0) |-> irq_rcv_xfer); // R5

endmodule

// File: tb/mbox_fifo_chan_tb_top.sv
module mbox_fifo_chan_tb_top;
  localparam int DW    = 16;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst;
  logic          wr, wa, rd, ack, fl, flc, ackc, ovfc;
  logic [DW-1:0] wd;
  logic [CW-1:0] lo_mark, hi_mark;
  logic [DW-1:0] rd_data;
  logic          rd_needack, ovf, irq_x, irq_a, irq_lo, irq_hi, irq_f;
  logic [CW-1:0] fill, depth;

  mbox_fifo_chan #(.DW(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .snd_wr_en(wr), .snd_wr_data(wd), .snd_wr_needack(wa),
    .snd_flush(fl), .snd_ack_clr(ackc), .snd_flush_clr(flc), .snd_ovf_clr(ovfc),
    .cfg_low_mark(lo_mark), .cfg_high_mark(hi_mark), .rcv_rd_en(rd), .rcv_ack(ack),
    .rcv_rd_data(rd_data), .rcv_rd_needack(rd_needack), .fill_level(fill),
    .depth_value(depth), .ovf_sticky(ovf), .irq_rcv_xfer(irq_x), .irq_snd_ack(irq_a),
    .irq_low_tide(irq_lo), .irq_high_tide(irq_hi), .irq_flush(irq_f)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // reference model state
  logic [DW:0]   mq[$];
  logic [DW-1:0] m_rd;
  logic          m_rdack, m_ovf, m_fl, m_ackirq, m_pend, m_lastpop;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_lo(input int sz); return CW'(sz) <= lo_mark; endfunction
  function automatic logic exp_hi(input int sz); return CW'(sz) >= hi_mark; endfunction

  task automatic model_reset();
    mq.delete();
    m_rd = '0; m_rdack = 0; m_ovf = 0; m_fl = 0; m_ackirq = 0; m_pend = 0; m_lastpop = 0;
  endtask

  task automatic model_step();
    logic eff, hit, popped, full, empty;
    logic [DW:0] e;
    eff = m_pend | m_lastpop;
    if (ackc) m_ackirq = 0;
    if (ovfc) m_ovf = 0;
    if (flc)  m_fl = 0;
    if (fl) begin
      mq.delete();
      m_fl = 1; m_pend = 0; m_lastpop = 0;
    end else begin
      full = (mq.size() == DEPTH);
      empty = (mq.size() == 0);
      popped = 0;
      if (rd) begin
        if (empty) begin m_rd = '0; m_rdack = 0; end
        else begin e = mq.pop_front(); m_rd = e[DW-1:0]; m_rdack = e[DW]; popped = e[DW]; end
      end
      if (wr) begin
        if (full) m_ovf = 1;
        else mq.push_back({wa, wd});
      end
      hit = ack & eff;
      if (hit) m_ackirq = 1;
      m_pend = hit ? 1'b0 : eff;
      m_lastpop = popped;
    end
  endtask

  task automatic check_all();
    chk("R11", "fill_level", 64'(fill), 64'(mq.size()));
    chk("R2", "rcv_rd_data", 64'(rd_data), 64'(m_rd));
    chk("R2", "rcv_rd_needack", 64'(rd_needack), 64'(m_rdack));
    chk("R5", "irq_rcv_xfer", 64'(irq_x), 64'(mq.size() != 0));
    chk("R6", "irq_high_tide", 64'(irq_hi), 64'(exp_hi(mq.size())));
    chk("R7", "irq_low_tide", 64'(irq_lo), 64'(exp_lo(mq.size())));
    chk("R3", "ovf_sticky", 64'(ovf), 64'(m_ovf));
    chk("R8", "irq_snd_ack", 64'(irq_a), 64'(m_ackirq));
    chk("R9", "irq_flush", 64'(irq_f), 64'(m_fl));
  endtask

  task automatic idle_inputs();
    wr = 0; wd = '0; wa = 0; rd = 0; ack = 0; fl = 0; flc = 0; ackc = 0; ovfc = 0;
  endtask

  // one clock: inputs already driven at a falling edge
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
    idle_inputs();
  endtask

  task automatic push(input logic [DW-1:0] d, input logic a);
    wr = 1; wd = d; wa = a; cyc();
  endtask

  task automatic pop();
    rd = 1; cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    idle_inputs();
    lo_mark = CW'(2);
    hi_mark = CW'(6);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    model_reset();
    // R1 reset state
    chk("R1", "reset fill", 64'(fill), 0);
    chk("R1", "reset data", 64'(rd_data), 0);
    chk("R1", "reset irqs", 64'({irq_x, irq_a, irq_hi, irq_f, ovf}), 0);
    chk("R1", "reset low tide", 64'(irq_lo), 1);
    chk("R10", "depth_value", 64'(depth), DEPTH);

    // R2 ordering
    push(16'hA001, 0); push(16'hA002, 0); push(16'hA003, 0);
    pop(); chk("R2", "first out", 64'(rd_data), 16'hA001);
    pop(); chk("R2", "second out", 64'(rd_data), 16'hA002);
    pop(); chk("R2", "third out", 64'(rd_data), 16'hA003);

    // R4 empty pop
    pop(); chk("R4", "empty pop data", 64'(rd_data), 0);
    chk("R4", "empty pop fill", 64'(fill), 0);

    // R3 overflow, with tide boundaries passed on the way
    for (int i = 0; i < DEPTH; i++) push(DW'(16'hB000 + i), 0);
    chk("R6", "high tide at full", 64'(irq_hi), 1);
    push(16'hDEAD, 0);
    chk("R3", "drop keeps full", 64'(fill), DEPTH);
    chk("R3", "overflow latched", 64'(ovf), 1);
    wr = 1; wd = 16'hBEEF; rd = 1; cyc();
    chk("R3", "full push+pop dropped", 64'(fill), DEPTH - 1);
    ovfc = 1; cyc();
    chk("R3", "overflow cleared", 64'(ovf), 0);

    // R11 balanced traffic
    wr = 1; wd = 16'hC0DE; rd = 1; cyc();
    chk("R11", "balanced fill", 64'(fill), DEPTH - 1);
    while (mq.size() != 0) pop();
    chk("R7", "low tide when drained", 64'(irq_lo), 1);

    // R8 acknowledge round trip
    ack = 1; cyc();
    chk("R8", "ack without pending", 64'(irq_a), 0);
    push(16'h0A0A, 1);
    pop(); chk("R8", "flag visible", 64'(rd_needack), 1);
    ack = 1; cyc();
    chk("R8", "ack irq set", 64'(irq_a), 1);
    cyc(); cyc();
    chk("R8", "ack irq held", 64'(irq_a), 1);
    ackc = 1; cyc();
    chk("R8", "ack irq cleared", 64'(irq_a), 0);
    ack = 1; cyc();
    chk("R8", "second ack ignored", 64'(irq_a), 0);

    // R9 flush over a same-cycle push
    push(16'h1111, 0); push(16'h2222, 0);
    fl = 1; wr = 1; wd = 16'h3333; rd = 1; cyc();
    chk("R9", "flush empties", 64'(fill), 0);
    chk("R9", "flush irq", 64'(irq_f), 1);
    flc = 1; cyc();
    chk("R9", "flush irq cleared", 64'(irq_f), 0);

    // constrained random traffic
    lo_mark = CW'(3);
    hi_mark = CW'(5);
    for (int n = 0; n < 4000; n++) begin
      wr   = ($urandom_range(99) < 50);
      wd   = DW'($urandom);
      wa   = ($urandom_range(99) < 30);
      rd   = ($urandom_range(99) < 45);
      ack  = ($urandom_range(99) < 20);
      fl   = ($urandom_range(99) < 2);
      flc  = ($urandom_range(99) < 10);
      ackc = ($urandom_range(99) < 10);
      ovfc = ($urandom_range(99) < 10);
      cyc();
    end
    chk("R10", "depth_value final", 64'(depth), DEPTH);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule